// File: doc/BRIEF.md
# 8-bit ALU with Packed Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. It combines an adder/subtractor and a bitwise logic unit. Both work on two 8-bit operands. The 8-bit result comes out combinationally in the same cycle. Beside them sits a registered status byte. The status byte captures carry, zero, negative, overflow, sign and half-carry after each operation that asks for a flag update.

The surrounding core selects the operation and raises the flag-update enable for instructions that affect flags. It can also overwrite the whole status byte through a direct write port, for example when status is restored after an interrupt. The two top flags are an interrupt-enable bit and a bit-copy bit. The block stores them, but only a direct write changes them. The carry-chained operations take their carry-in or borrow-in from the stored carry flag. Chained multi-byte arithmetic needs no extra input for this.

Top module: `alu8_status`

## Requirements
- R1: While rst_ni is low, and after it rises until the first write or update, sreg_o is 0x00.
- R2: op_sel_i encodes 0=ADD (a+b), 1=ADC (a+b+C), 2=SUB (a-b), 3=SBC (a-b-C), 4=AND, 5=OR, 6=XOR and 7=PASS (result = op_b_i). result_o is the 8-bit result, valid in the same cycle.
- R3: Status bit 0 (C) takes the carry out of bit 7 after ADD/ADC. After SUB/SBC it takes the borrow, which is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R4: Status bit 1 (Z) becomes 1 exactly when the result is zero. Status bit 2 (N) becomes bit 7 of the result. Both apply to every operation except PASS.
- R5: Status bit 3 (V) is set when the signed result of an add or subtract does not fit in 8 bits. AND, OR and XOR clear V.
- R6: Status bit 4 (S) becomes N XOR V of the same update.
- R7: Status bit 5 (H) takes the carry from bit 3 into bit 4 after ADD/ADC. After SUB/SBC it takes the borrow from bit 4 into bit 3 (low nibble of a smaller than low nibble of b plus borrow-in).
- R8: ADC adds the stored C as carry-in. SBC subtracts the stored C as borrow-in.
- R9: AND, OR and XOR leave C and H unchanged. PASS leaves all eight status bits unchanged.
- R10: Flags change on a rising clock edge only when flag_upd_i is high. Status bits 7 (I) and 6 (T) never change through a flag update.
- R11: When sreg_we_i is high, all eight status bits load sreg_wdata_i on the clock edge. This takes priority over a flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | First operand (minuend for subtraction) |
| op_b_i | input | 8 | Second operand |
| op_sel_i | input | 3 | Operation select, encoding per R2 |
| flag_upd_i | input | 1 | Capture the flags of the current operation |
| sreg_we_i | input | 1 | Direct write of the status byte |
| sreg_wdata_i | input | 8 | Value for the direct write |
| result_o | output | 8 | Operation result |
| sreg_o | output | 8 | Status byte, bit 7 down to 0: I T H S V N Z C |

## Verification
The bench drives the signed boundaries 0x7F+1 and 0x80-1, and the wrap 0xFF+1. A design with the wrong overflow equation or a missing carry shows a wrong V, S or C there, and a Z that stays low on a zero result. Chained ADC and SBC are run with the stored carry both set and clear. This catches a carry-in that is ignored or has the wrong polarity during a subtract. Logic operations follow an operation that set C and H, so a unit that clears them instead of keeping them shows up. Cycles with the enable low, and cycles where write and update arrive together, expose flags that update freely and a priority that is reversed.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBC  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              chain_i,
  input  logic              c_stored_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   sum_full;
  logic [NIB:0]      sum_low;

  // subtraction as a + ~b + 1, borrow-in removes the +1
  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    cin      = sub_i ? ~(chain_i & c_stored_i) : (chain_i & c_stored_i);
    sum_full = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    sum_low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};
    res_o    = sum_full[DATA_W-1:0];
    c_o      = sum_full[DATA_W] ^ sub_i;
    h_o      = sum_low[NIB] ^ sub_i;
    v_o      = (a_i[DATA_W-1] == b_eff[DATA_W-1]) && (res_o[DATA_W-1] != a_i[DATA_W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu8_pkg::alu_op_e op_i,
  output logic [DATA_W-1:0] res_o
);
  import alu8_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              upd_i,
  input  logic              is_arith_i,
  input  logic              is_logic_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              c_i,
  input  logic              h_i,
  input  logic              v_i,
  output logic [7:0]        sreg_o
);
  import alu8_pkg::*;

  logic [7:0] sreg_q, sreg_d, upd_val;
  logic       n_new, v_new;

  always_comb begin
    upd_val = sreg_q;
    n_new   = res_i[DATA_W-1];
    v_new   = is_arith_i ? v_i : 1'b0;
    if (is_arith_i || is_logic_i) begin
      upd_val[FL_Z] = (res_i == '0);
      upd_val[FL_N] = n_new;
      upd_val[FL_V] = v_new;
      upd_val[FL_S] = n_new ^ v_new;
    end
    if (is_arith_i) begin
      upd_val[FL_C] = c_i;
      upd_val[FL_H] = h_i;
    end
    if (we_i)       sreg_d = wdata_i;
    else if (upd_i) sreg_d = upd_val;
    else            sreg_d = sreg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= 8'h00;
    else         sreg_q <= sreg_d;
  end

  assign sreg_o = sreg_q;

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sreg_q == $past(wdata_i)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !upd_i) |=> $stable(sreg_q)); // R10
  AST_IT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> sreg_q[7:6] == $past(sreg_q[7:6])); // R10
  AST_SIGN_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !we_i && (is_arith_i || is_logic_i)) |=> sreg_q[FL_S] == (sreg_q[FL_N] ^ sreg_q[FL_V])); // R6
  AST_LOGIC_KEEP_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !we_i && is_logic_i) |=> (sreg_q[FL_C] == $past(sreg_q[FL_C])) && (sreg_q[FL_H] == $past(sreg_q[FL_H])) && !sreg_q[FL_V]); // R9
  AST_PASS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !is_arith_i && !is_logic_i) |=> $stable(sreg_q)); // R9
endmodule

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] op_a_i,
  input  logic [7:0] op_b_i,
  input  logic [2:0] op_sel_i,
  input  logic       flag_upd_i,
  input  logic       sreg_we_i,
  input  logic [7:0] sreg_wdata_i,
  output logic [7:0] result_o,
  output logic [7:0] sreg_o
);
  import alu8_pkg::*;

  localparam int DATA_W = 8;

  alu_op_e           op;
  logic              is_arith, is_logic, is_sub, is_chain;
  logic [DATA_W-1:0] arith_res, logic_res;
  logic              c_flag, h_flag, v_flag;

  assign op       = alu_op_e'(op_sel_i);
  assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC);
  assign is_chain = (op == OP_ADC) || (op == OP_SBC);

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .sub_i      (is_sub),
    .chain_i    (is_chain),
    .c_stored_i (sreg_o[FL_C]),
    .res_o      (arith_res),
    .c_o        (c_flag),
    .h_o        (h_flag),
    .v_o        (v_flag)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .op_i  (op),
    .res_o (logic_res)
  );

  assign result_o = is_arith ? arith_res : logic_res;

  alu8_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sreg_we_i),
    .wdata_i    (sreg_wdata_i),
    .upd_i      (flag_upd_i),
    .is_arith_i (is_arith),
    .is_logic_i (is_logic),
    .res_i      (result_o),
    .c_i        (c_flag),
    .h_i        (h_flag),
    .v_i        (v_flag),
    .sreg_o     (sreg_o)
  );

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_upd_i && !sreg_we_i && op_sel_i != 3'd7) |=> sreg_o[FL_Z] == ($past(result_o) == 8'h00)); // R4
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_upd_i && !sreg_we_i && op_sel_i != 3'd7) |=> sreg_o[FL_N] == $past(result_o[7])); // R4
  AST_PASS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_sel_i == 3'd7 |-> result_o == op_b_i); // R2
endmodule

// File: tb/alu8_status_tb.sv
module alu8_status_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] op_a_i = '0, op_b_i = '0, sreg_wdata_i = '0;
  logic [2:0] op_sel_i = '0;
  logic       flag_upd_i = 1'b0, sreg_we_i = 1'b0;
  logic [7:0] result_o, sreg_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model_sreg = 8'h00;

  alu8_status dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_result(input logic [7:0] a, input logic [7:0] b,
                                            input logic [2:0] op, input logic c);
    int r;
    case (op)
      3'd0: r = int'(a) + int'(b);
      3'd1: r = int'(a) + int'(b) + int'(c);
      3'd2: r = int'(a) - int'(b);
      3'd3: r = int'(a) - int'(b) - int'(c);
      3'd4: r = int'(a & b);
      3'd5: r = int'(a | b);
      3'd6: r = int'(a ^ b);
      default: r = int'(b);
    endcase
    return r[7:0];
  endfunction

  function automatic logic [7:0] ref_sreg(input logic [7:0] a, input logic [7:0] b,
                                          input logic [2:0] op, input logic [7:0] s);
    logic [7:0] n = s;
    logic [7:0] res;
    int ci, u, lo, sg;
    bit sub;
    ci  = (op == 3'd1 || op == 3'd3) ? int'(s[0]) : 0;
    sub = (op == 3'd2 || op == 3'd3);
    res = ref_result(a, b, op, s[0]);
    if (op == 3'd7) return s;
    n[1] = (res == 8'h00);
    n[2] = res[7];
    if (op <= 3'd3) begin
      if (sub) begin
        u  = int'(a) - int'(b) - ci;
        lo = int'(a[3:0]) - int'(b[3:0]) - ci;
        sg = int'($signed(a)) - int'($signed(b)) - ci;
        n[0] = (u < 0);
        n[5] = (lo < 0);
      end else begin
        u  = int'(a) + int'(b) + ci;
        lo = int'(a[3:0]) + int'(b[3:0]) + ci;
        sg = int'($signed(a)) + int'($signed(b)) + ci;
        n[0] = (u > 255);
        n[5] = (lo > 15);
      end
      n[3] = (sg > 127) || (sg < -128);
    end else n[3] = 1'b0;
    n[4] = n[2] ^ n[3];
    return n;
  endfunction

  // drive at negedge, check result before the edge, status after it
  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                      input bit upd, input bit we, input logic [7:0] wd, input string req);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; op_sel_i = op;
    flag_upd_i = upd; sreg_we_i = we; sreg_wdata_i = wd;
    #1;
    check({req, " R2 result"}, result_o, ref_result(a, b, op, model_sreg[0]));
    if (we)       model_sreg = wd;
    else if (upd) model_sreg = ref_sreg(a, b, op, model_sreg);
    @(posedge clk_i);
    #1;
    check({req, " status"}, sreg_o, model_sreg);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a1b));
    #3;
    check("R1 reset", sreg_o, 8'h00);
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 after reset", sreg_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 held", sreg_o, 8'h00);

    step(8'h7F, 8'h01, 3'd0, 1, 0, 8'h00, "R5 R6 0x7F+1");
    check("R5 V on 0x7F+1", {7'd0, sreg_o[3]}, 8'h01);
    step(8'h80, 8'h01, 3'd2, 1, 0, 8'h00, "R5 R7 0x80-1");
    check("R7 H borrow on 0x80-1", {7'd0, sreg_o[5]}, 8'h01);
    step(8'hFF, 8'h01, 3'd0, 1, 0, 8'h00, "R3 R4 0xFF+1");
    check("R4 Z on 0xFF+1", {7'd0, sreg_o[1]}, 8'h01);
    check("R3 C on 0xFF+1", {7'd0, sreg_o[0]}, 8'h01);
    step(8'h10, 8'h20, 3'd1, 1, 0, 8'h00, "R8 ADC with C=1");
    step(8'h10, 8'h20, 3'd1, 1, 0, 8'h00, "R8 ADC with C=0");
    step(8'h05, 8'h09, 3'd2, 1, 0, 8'h00, "R3 SUB borrow");
    step(8'h30, 8'h10, 3'd3, 1, 0, 8'h00, "R8 SBC with C=1");
    step(8'h30, 8'h10, 3'd3, 1, 0, 8'h00, "R8 SBC with C=0");
    step(8'h00, 8'h01, 3'd2, 1, 0, 8'h00, "R3 R7 0-1");
    step(8'hF0, 8'h0F, 3'd4, 1, 0, 8'h00, "R9 AND keeps C H");
    step(8'h80, 8'h01, 3'd5, 1, 0, 8'h00, "R9 OR keeps C H");
    step(8'hAA, 8'hAA, 3'd6, 1, 0, 8'h00, "R4 XOR zero");
    step(8'h12, 8'h00, 3'd7, 1, 0, 8'h00, "R9 PASS keeps flags");
    step(8'hFF, 8'h01, 3'd0, 0, 0, 8'h00, "R10 enable low");
    step(8'h01, 8'h01, 3'd0, 1, 1, 8'hC3, "R11 write beats update");
    step(8'h7F, 8'h7F, 3'd0, 1, 0, 8'h00, "R10 I T kept on update");
    check("R10 I T bits", sreg_o & 8'hC0, 8'hC0);
    step(8'h00, 8'h00, 3'd4, 0, 1, 8'h3C, "R11 write all bits");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, b, wd;
      logic [2:0] op;
      bit upd, we;
      a   = 8'($urandom());
      b   = 8'($urandom());
      op  = 3'($urandom());
      upd = ($urandom() % 4) != 0;
      we  = ($urandom() % 16) == 0;
      wd  = 8'($urandom());
      if (($urandom() % 8) == 0) a = ($urandom() % 2) ? 8'h7F : 8'h80;
      if (($urandom() % 8) == 0) b = ($urandom() % 2) ? 8'hFF : 8'h01;
      step(a, b, op, upd, we, wd, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule